// File: doc/BRIEF.md
# Up-counter timer with edge capture

This block is a 16-bit up-counter with a small register bus. The count can advance on one of four sources: rising edges of an external input pin, or one of three prescaler ticks. A run bit starts and stops the counter. An optional clear returns the count to zero after it reaches a compare value. A one-cycle match strobe is available to neighbouring logic.

Two capture registers record the count at edges of a capture source. The source is either the external pin or the output of a companion timer. Software can also take a snapshot of the count by writing the mode register. Every rising edge of the pin raises a one-cycle interrupt pulse.

Both asynchronous inputs, the pin and the companion output, pass through a two-flop synchronizer before edge detection. The prescaler ticks are taken as already synchronous. Bus reads are combinational from the selected register. Writes take effect at the clock edge on which `bus_we` is high.

Register map (`bus_addr`):
- 0 is the mode register.
- 1 is the compare value.
- 2 is capture register 0.
- 3 is capture register 1.

Mode register fields:
- bits [1:0] are the source select.
- bit 2 is run.
- bit 3 is clear-enable.
- bits [5:4] are the capture mode.
- bit 6 is the software-capture bit.

Top module: `upcap_timer`

## Requirements
- R1: After reset, address 0 reads 0x0040, meaning only bit 6 is set. Addresses 1, 2 and 3 read 0. `irq_pulse` and `match_pulse` are low.
- R2: Source select works as follows: 00 counts synchronized rising edges of `cap_pin`, 01 counts `tick_fine`, 10 counts `tick_div4`, and 11 counts `tick_div16`. The sources that are not selected have no effect on the count.
- R3: With run (bit 2) at 0, the count holds regardless of ticks.
- R4: `match_pulse` is high for one cycle on each counting advance taken while the count equals the compare value, whatever the setting of clear-enable. With clear-enable (bit 3) set, that advance loads 0 instead of count+1.
- R5: With clear-enable at 0, the count wraps from 0xFFFF to 0x0000.
- R6: Capture mode 00 leaves both capture registers unchanged on pin and companion edges.
- R7: Capture mode 01 copies the count into capture register 0 on each rising pin edge. Falling edges are ignored.
- R8: Capture mode 10 copies the count into capture register 0 on rising pin edges and into capture register 1 on falling pin edges.
- R9: Capture mode 11 behaves like mode 10, but takes its edges from `peer_out`. Pin edges then capture nothing.
- R10: A mode write with bit 6 at 0 copies the current count into capture register 0 in the same clock. A write with bit 6 at 1 captures nothing. Bit 6 always reads back as 1.
- R11: Each rising edge of `cap_pin` gives exactly one single-cycle `irq_pulse`, in every capture mode.
- R12: The compare register at address 1 reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| cap_pin | input | 1 | External pin, asynchronous |
| peer_out | input | 1 | Companion timer output, asynchronous |
| tick_fine | input | 1 | Fastest prescaler tick |
| tick_div4 | input | 1 | Prescaler tick, four times slower |
| tick_div16 | input | 1 | Prescaler tick, sixteen times slower |
| irq_pulse | output | 1 | One-cycle pulse on a pin rising edge |
| match_pulse | output | 1 | One-cycle pulse on an advance taken at the compare value |

## Verification
The bench drives ticks on the sources that are not selected. A wrong multiplexer then shows up as an inflated count in a software snapshot.

In capture mode 11 the bench toggles the pin. A design that still listened to the pin would overwrite capture register 0.

The bench counts through compare with clear enabled. An off-by-one clear would leave the snapshot at 3 instead of 2. It also runs a full 65535-tick wrap, which would expose a design that saturates or clears at 0xFFFF.

Writes with bit 6 set must leave capture register 0 untouched. A design that stored bit 6 as an ordinary field would read back 0 after a snapshot write.

// File: rtl/upcap_timer.sv
module upcap_timer #(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic          cap_pin,
  input  logic          peer_out,
  input  logic          tick_fine,
  input  logic          tick_div4,
  input  logic          tick_div16,
  output logic          irq_pulse,
  output logic          match_pulse
);
  localparam logic [AW-1:0] A_MODE = AW'(0);
  localparam logic [AW-1:0] A_CMP  = AW'(1);
  localparam logic [AW-1:0] A_CAP0 = AW'(2);
  localparam logic [AW-1:0] A_CAP1 = AW'(3);

  logic [1:0]   src_sel, cap_mode;
  logic         run, clr_en;
  logic [W-1:0] cnt, cmp, cap0, cap1;
  logic [2:0]   pin_sy, peer_sy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_sy  <= '0;
      peer_sy <= '0;
    end else begin
      pin_sy  <= {pin_sy[1:0], cap_pin};
      peer_sy <= {peer_sy[1:0], peer_out};
    end
  end

  wire pin_rise  =  pin_sy[1]  & ~pin_sy[2];
  wire pin_fall  = ~pin_sy[1]  &  pin_sy[2];
  wire peer_rise =  peer_sy[1] & ~peer_sy[2];
  wire peer_fall = ~peer_sy[1] &  peer_sy[2];

  logic tick_sel;
  always_comb begin
    case (src_sel)
      2'b00:   tick_sel = pin_rise;
      2'b01:   tick_sel = tick_fine;
      2'b10:   tick_sel = tick_div4;
      default: tick_sel = tick_div16;
    endcase
  end

  wire adv     = run & tick_sel;
  wire hit     = (cnt == cmp);
  wire mode_wr = bus_we && bus_addr == A_MODE;
  wire sw_cap  = mode_wr && !bus_wdata[6];
  wire s_rise  = (cap_mode == 2'b11) ? peer_rise : pin_rise;
  wire s_fall  = (cap_mode == 2'b11) ? peer_fall : pin_fall;
  wire cap0_ev = sw_cap | ((cap_mode != 2'b00) & s_rise);
  wire cap1_ev = cap_mode[1] & s_fall;

  assign irq_pulse   = pin_rise;
  assign match_pulse = adv & hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_sel  <= 2'b00;
      run      <= 1'b0;
      clr_en   <= 1'b0;
      cap_mode <= 2'b00;
      cmp      <= '0;
      cnt      <= '0;
      cap0     <= '0;
      cap1     <= '0;
    end else begin
      if (mode_wr) begin
        src_sel  <= bus_wdata[1:0];
        run      <= bus_wdata[2];
        clr_en   <= bus_wdata[3];
        cap_mode <= bus_wdata[5:4];
      end
      if (bus_we && bus_addr == A_CMP) cmp <= bus_wdata;
      if (adv) cnt <= (clr_en && hit) ? '0 : cnt + 1'b1;
      if (cap0_ev) cap0 <= cnt;
      if (cap1_ev) cap1 <= cnt;
    end
  end

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = W'({1'b1, cap_mode, clr_en, run, src_sel});
      A_CMP:   bus_rdata = cmp;
      A_CAP0:  bus_rdata = cap0;
      A_CAP1:  bus_rdata = cap1;
      default: bus_rdata = '0;
    endcase
  end

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt));
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && clr_en && hit) |=> cnt == '0);
  a_r4_match_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> run);
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt == '1 && !(clr_en && hit)) |=> cnt == '0);
  a_r6_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode == 2'b00 && !mode_wr) |=> ($stable(cap0) && $stable(cap1)));
  a_r8_fall_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode == 2'b10 && pin_fall) |=> cap1 == $past(cnt));
  a_r11_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
endmodule

// File: tb/upcap_timer_bench.sv
module upcap_timer_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic cap_pin = 1'b0, peer_out = 1'b0;
  logic tick_fine = 1'b0, tick_div4 = 1'b0, tick_div16 = 1'b0;
  logic irq_pulse, match_pulse;

  upcap_timer u_upcap_timer (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_pin(cap_pin),
    .peer_out(peer_out), .tick_fine(tick_fine), .tick_div4(tick_div4),
    .tick_div16(tick_div16), .irq_pulse(irq_pulse), .match_pulse(match_pulse));

  always #(CLK_P/2) clk = ~clk;

  typedef struct { logic [2:0] a; logic [15:0] v; string tag; } exp_t;
  exp_t exp_q[$];
  int checks = 0, errors = 0, irq_cnt = 0, match_cnt = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_pulse) irq_cnt++;
      if (match_pulse) match_cnt++;
    end
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (bus_rdata !== e.v) begin
        errors++;
        $display("FAIL %s addr %0d actual 0x%04h expected 0x%04h", e.tag, e.a, bus_rdata, e.v);
      end
    end
  end

  function automatic logic [15:0] mode(input logic [1:0] src, input logic rn, input logic clr,
                                       input logic [1:0] cm, input logic sw);
    return {9'b0, sw, cm, clr, rn, src};
  endfunction

  task automatic expect_rd(input logic [2:0] a, input logic [15:0] v, input string tag);
    exp_t e;
    @(posedge clk); #1;
    bus_addr = a;
    e.a = a; e.v = v; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic ticks(input int sel, input int n);
    @(posedge clk); #1;
    case (sel)
      1: tick_fine = 1'b1;
      2: tick_div4 = 1'b1;
      default: tick_div16 = 1'b1;
    endcase
    repeat (n) @(posedge clk);
    #1;
    tick_fine = 1'b0; tick_div4 = 1'b0; tick_div16 = 1'b0;
  endtask

  task automatic pin(input logic v);
    @(posedge clk); #1; cap_pin = v;
    repeat (4) @(posedge clk);
  endtask

  task automatic peer(input logic v);
    @(posedge clk); #1; peer_out = v;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(irq_pulse === 1'b0 && match_pulse === 1'b0, "R1 pulses low", irq_pulse, 0);
    expect_rd(0, 16'h0040, "R1 mode reset");
    expect_rd(1, 16'h0000, "R1 cmp reset");
    expect_rd(2, 16'h0000, "R1 cap0 reset");
    expect_rd(3, 16'h0000, "R1 cap1 reset");

    wr(1, 16'h1234);
    expect_rd(1, 16'h1234, "R12 cmp readback");

    // R2 fine source, R10 software capture
    wr(0, mode(2'b01, 1, 0, 2'b00, 1));
    ticks(1, 10);
    wr(0, mode(2'b01, 1, 0, 2'b00, 0));
    expect_rd(2, 16'd10, "R10 sw capture");
    expect_rd(0, mode(2'b01, 1, 0, 2'b00, 1), "R10 bit6 reads one");
    wr(0, mode(2'b01, 1, 0, 2'b00, 1));
    expect_rd(2, 16'd10, "R10 write one no capture");

    // R2 unselected source ignored, then div4 and div16
    ticks(2, 5);
    wr(0, mode(2'b01, 1, 0, 2'b00, 0));
    expect_rd(2, 16'd10, "R2 unselected div4 ignored");
    wr(0, mode(2'b10, 1, 0, 2'b00, 1));
    ticks(2, 5);
    wr(0, mode(2'b10, 1, 0, 2'b00, 0));
    expect_rd(2, 16'd15, "R2 div4 source");
    wr(0, mode(2'b11, 1, 0, 2'b00, 1));
    ticks(3, 3);
    wr(0, mode(2'b11, 1, 0, 2'b00, 0));
    expect_rd(2, 16'd18, "R2 div16 source");

    // R3 run off holds
    wr(0, mode(2'b11, 0, 0, 2'b00, 1));
    ticks(3, 7);
    wr(0, mode(2'b11, 0, 0, 2'b00, 0));
    expect_rd(2, 16'd18, "R3 stopped holds");

    // R4 clear at compare: 18,19,20,0,1,2
    wr(1, 16'd20);
    match_cnt = 0;
    wr(0, mode(2'b01, 1, 1, 2'b00, 1));
    ticks(1, 5);
    wr(0, mode(2'b01, 1, 1, 2'b00, 0));
    expect_rd(2, 16'd2, "R4 clear on match");
    chk(match_cnt == 1, "R4 match pulse count", match_cnt, 1);

    // R5 wrap: 2 + 65535 -> 1, one match passing 20
    match_cnt = 0;
    wr(0, mode(2'b01, 1, 0, 2'b00, 1));
    ticks(1, 65535);
    wr(0, mode(2'b01, 0, 0, 2'b00, 0));
    expect_rd(2, 16'd1, "R5 wrap");
    chk(match_cnt == 1, "R4 match without clear", match_cnt, 1);

    // R6 capture disabled, R11 irq
    irq_cnt = 0;
    pin(1); pin(0);
    expect_rd(2, 16'd1, "R6 cap0 unchanged");
    expect_rd(3, 16'd0, "R6 cap1 unchanged");
    chk(irq_cnt == 1, "R11 irq in mode 00", irq_cnt, 1);

    // R7 rising only
    wr(0, mode(2'b01, 1, 0, 2'b01, 1));
    ticks(1, 6);
    wr(0, mode(2'b01, 0, 0, 2'b01, 1));
    pin(1);
    expect_rd(2, 16'd7, "R7 rise to cap0");
    pin(0);
    expect_rd(3, 16'd0, "R7 fall ignored");

    // R8 dual edge from pin
    wr(0, mode(2'b01, 1, 0, 2'b10, 1));
    ticks(1, 3);
    wr(0, mode(2'b01, 0, 0, 2'b10, 1));
    pin(1);
    expect_rd(2, 16'd10, "R8 rise to cap0");
    wr(0, mode(2'b01, 1, 0, 2'b10, 1));
    ticks(1, 4);
    wr(0, mode(2'b01, 0, 0, 2'b10, 1));
    pin(0);
    expect_rd(3, 16'd14, "R8 fall to cap1");
    expect_rd(2, 16'd10, "R8 cap0 kept");

    // R9 companion source
    wr(0, mode(2'b01, 1, 0, 2'b11, 1));
    ticks(1, 2);
    wr(0, mode(2'b01, 0, 0, 2'b11, 1));
    irq_cnt = 0;
    pin(1);
    expect_rd(2, 16'd10, "R9 pin ignored");
    chk(irq_cnt == 1, "R11 irq in mode 11", irq_cnt, 1);
    peer(1);
    expect_rd(2, 16'd16, "R9 peer rise to cap0");
    pin(0);
    expect_rd(3, 16'd14, "R9 pin fall ignored");
    wr(0, mode(2'b01, 1, 0, 2'b11, 1));
    ticks(1, 1);
    wr(0, mode(2'b01, 0, 0, 2'b11, 1));
    peer(0);
    expect_rd(3, 16'd17, "R9 peer fall to cap1");

    // R2 pin source: 17 + 3 pin edges, fine tick ignored
    wr(0, mode(2'b00, 1, 0, 2'b00, 1));
    ticks(1, 9);
    pin(1); pin(0); pin(1); pin(0); pin(1); pin(0);
    wr(0, mode(2'b00, 0, 0, 2'b00, 0));
    expect_rd(2, 16'd20, "R2 pin source");

    repeat (2) @(posedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule